// File: doc/BRIEF.md
# ADC Input Mode Selector

This block chooses which source feeds a slow integrating ADC and decides whether the most recent conversion may be trusted. It holds a 2-bit source-mode register, counts out a settling delay after the source changes or after a DAC change that reaches the measured path, and captures conversion results into a data register. Software talks to it through a one-command-per-cycle port. A response arrives one cycle after each command and carries an accept flag. For reads, that flag is the data-valid indication.

The converter is not part of the block. It is represented by a one-cycle done strobe with its result word. Entering or leaving the self-test source is guarded so that a single stray write cannot do it. The guarded mode write is accepted only when an arm command came directly before it. The settling delay is a cycle count computed from the clock frequency and a delay in milliseconds. The default delay is 920 ms.

Top module: `adc_src_sel`

## Requirements
- R1: While reset is asserted, and on release, the source mode is 00 (analog input 2), `data_valid` is 0 and `settle_busy` is 1. Mode codes: 00 analog input 2, 01 analog input 1, 10 DAC monitor, 11 self-test.
- R2: Command codes on `cmd_op`: 00 arm, 01 mode write (new mode on `cmd_data`), 10 other write, 11 read. Every command gets exactly one response one cycle later. A mode write that neither enters nor leaves 11 is accepted (`resp_q`=1), and the mode takes the new value in that same edge.
- R3: A mode write that enters or leaves 11 is accepted only if the command directly before it was an arm. Otherwise it answers `resp_q`=0 and the mode does not change.
- R4: The arm state is set by an arm command. It is cleared by any mode write or other write. A read leaves it as it is. Reset clears it.
- R5: An accepted mode write that changes the mode clears `data_valid` and restarts the settle timer. A write of the current mode has no effect on either.
- R6: A `dac_change` pulse in mode 10 or 11 clears `data_valid` and restarts the settle timer. In mode 00 or 01 it has no effect.
- R7: A conversion-done strobe that arrives while `settle_busy` is 1 is discarded: the data register and `data_valid` keep their values. One that arrives after settling loads the data register and sets `data_valid`.
- R8: In mode 10 while `dac_ramping` is 1, a read answers `resp_q`=0 and conversion strobes are discarded.
- R9: A read returns the data register on `resp_data`, with `resp_q` equal to `data_valid` (subject to R8). All other commands return `resp_data`=0 and `resp_q`=1, except as R2 and R3 state.
- R10: Reset does not alter the data register. A read after reset returns the value captured before reset, with `resp_q`=0.
- R11: After a restart, `settle_busy` stays 1 for exactly CLK_HZ*SETTLE_MS/1000 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_en | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Command code (arm, mode write, other write, read) |
| cmd_data | input | 2 | New mode for a mode write |
| dac_change | input | 1 | Pulse: the DAC register changed |
| dac_ramping | input | 1 | Level: the DAC is ramping |
| conv_done | input | 1 | Converter result strobe |
| conv_data | input | DW | Converter result word |
| mode_o | output | 2 | Current source mode |
| data_valid | output | 1 | Data register holds a settled conversion |
| settle_busy | output | 1 | Settle timer running |
| resp_valid | output | 1 | Response to the previous cycle's command |
| resp_q | output | 1 | Accept flag, or validity for reads |
| resp_data | output | DW | Read data |

## Verification
A stuck or wrongly set arm state appears on the very next guarded mode write. It shows as a wrong `resp_q` and a wrong `mode_o` one cycle after that write. An off-by-one in the settle counter moves the falling edge of `settle_busy` by one cycle. The bench samples that edge at its exact cycle, and the change also decides whether a strobe placed just after settling gets captured. Wrong capture or hold of the data register shows up in the next read's `resp_data`, including the read after reset and the reads after strobes that should have been discarded.

// File: rtl/adc_sel_pkg.sv
package adc_sel_pkg;
  typedef enum logic [1:0] {
    SRC_AIN2     = 2'b00,
    SRC_AIN1     = 2'b01,
    SRC_DACMON   = 2'b10,
    SRC_SELFTEST = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    OP_ARM   = 2'b00,
    OP_MODE  = 2'b01,
    OP_OTHER = 2'b10,
    OP_READ  = 2'b11
  } op_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/mode_ctl.sv
module mode_ctl
  import adc_sel_pkg::*;
(
  input  logic       clk,
  input  logic       srst_n,
  input  logic       cmd_en,
  input  logic [1:0] cmd_op,
  input  logic [1:0] cmd_data,
  output logic [1:0] mode_q,
  output logic       arm_q,
  output logic       mode_ok,
  output logic       mode_chg
);
  logic       is_mode_wr;
  logic       crosses_st;
  logic       arm_d;
  logic       arm_en;
  logic [1:0] mode_d;

  always_comb begin
    is_mode_wr = cmd_en && (cmd_op == OP_MODE);
    crosses_st = (mode_q == SRC_SELFTEST) != (cmd_data == SRC_SELFTEST);
    mode_ok    = !crosses_st || arm_q;
    mode_chg   = is_mode_wr && mode_ok && (cmd_data != mode_q);
    mode_d     = cmd_data;
    arm_en     = cmd_en && (cmd_op != OP_READ);
    arm_d      = (cmd_op == OP_ARM);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       mode_q <= SRC_AIN2;
    else if (mode_chg) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     arm_q <= 1'b0;
    else if (arm_en) arm_q <= arm_d;
  end
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int unsigned SETTLE_CYC = 46,
  localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic srst_n,
  input  logic restart,
  output logic busy
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    busy   = (cnt_q != '0);
    cnt_en = restart || busy;
    cnt_d  = restart ? LOAD : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     cnt_q <= LOAD;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/result_latch.sv
module result_latch #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  input  logic          invalidate,
  input  logic          settled,
  input  logic          blocked,
  output logic [DW-1:0] data_q,
  output logic          valid_q
);
  logic take;
  logic valid_en;
  logic valid_d;

  always_comb begin
    take     = conv_done && settled && !invalidate && !blocked;
    valid_en = take || invalidate;
    valid_d  = !invalidate;
  end

  // Data register has no reset: its content survives a reset.
  always_ff @(posedge clk) begin
    if (take) data_q <= conv_data;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       valid_q <= 1'b0;
    else if (valid_en) valid_q <= valid_d;
  end
endmodule

// File: rtl/adc_src_sel.sv
module adc_src_sel
  import adc_sel_pkg::*;
#(
  parameter int DW        = 16,
  parameter int CLK_HZ    = 100_000_000,
  parameter int SETTLE_MS = 920,
  localparam longint SETTLE_L = (longint'(CLK_HZ) * longint'(SETTLE_MS)) / 1000,
  localparam int unsigned SETTLE_CYC = 32'(SETTLE_L)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_en,
  input  logic [1:0]    cmd_op,
  input  logic [1:0]    cmd_data,
  input  logic          dac_change,
  input  logic          dac_ramping,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_data,
  output logic [1:0]    mode_o,
  output logic          data_valid,
  output logic          settle_busy,
  output logic          resp_valid,
  output logic          resp_q,
  output logic [DW-1:0] resp_data
);
  logic          srst_n;
  logic [1:0]    mode_q;
  logic          arm_q;
  logic          mode_ok;
  logic          mode_chg;
  logic          dac_hit;
  logic          invalidate;
  logic          mon_ramp;
  logic          busy;
  logic [DW-1:0] data_q;
  logic          valid_q;

  logic          rsp_v_d;
  logic          rsp_q_d;
  logic [DW-1:0] rsp_data_d;

  rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  mode_ctl u_mode (
    .clk      (clk),
    .srst_n   (srst_n),
    .cmd_en   (cmd_en),
    .cmd_op   (cmd_op),
    .cmd_data (cmd_data),
    .mode_q   (mode_q),
    .arm_q    (arm_q),
    .mode_ok  (mode_ok),
    .mode_chg (mode_chg)
  );

  always_comb begin
    dac_hit    = dac_change && mode_q[1];
    invalidate = mode_chg || dac_hit;
    mon_ramp   = (mode_q == SRC_DACMON) && dac_ramping;
  end

  settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .srst_n  (srst_n),
    .restart (invalidate),
    .busy    (busy)
  );

  result_latch #(.DW(DW)) u_res (
    .clk        (clk),
    .srst_n     (srst_n),
    .conv_done  (conv_done),
    .conv_data  (conv_data),
    .invalidate (invalidate),
    .settled    (!busy),
    .blocked    (mon_ramp),
    .data_q     (data_q),
    .valid_q    (valid_q)
  );

  always_comb begin
    rsp_v_d    = cmd_en;
    rsp_q_d    = 1'b1;
    rsp_data_d = '0;
    case (cmd_op)
      OP_READ: begin
        rsp_q_d    = valid_q && !mon_ramp;
        rsp_data_d = data_q;
      end
      OP_MODE: rsp_q_d = mode_ok;
      default: rsp_q_d = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      resp_valid <= 1'b0;
      resp_q     <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= rsp_v_d;
      if (rsp_v_d) begin
        resp_q    <= rsp_q_d;
        resp_data <= rsp_data_d;
      end
    end
  end

  assign mode_o      = mode_q;
  assign data_valid  = valid_q;
  assign settle_busy = busy;
endmodule

// File: rtl/adc_sel_chk.sv
module adc_sel_chk (
  input logic       clk,
  input logic       srst_n,
  input logic [1:0] mode,
  input logic       arm_q,
  input logic       data_valid,
  input logic       settle_busy,
  input logic       conv_done,
  input logic       dac_change,
  input logic       dac_ramping,
  input logic       cmd_en,
  input logic [1:0] cmd_op,
  input logic       resp_valid,
  input logic       resp_q
);
  // R3
  st_guard_chk: assert property (@(posedge clk) disable iff (!srst_n)
    ((mode == 2'b11) != ($past(mode) == 2'b11)) |-> $past(arm_q));

  // R5
  switch_inval_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (mode != $past(mode)) |-> (!data_valid && settle_busy));

  // R6
  dac_path_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (dac_change && mode[1]) |=> (!data_valid && settle_busy));

  // R7
  rise_needs_conv_chk: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(data_valid) |-> ($past(conv_done) && !$past(settle_busy)));

  // R8
  ramp_read_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (resp_valid && $past(cmd_en && cmd_op == 2'b11 && mode == 2'b10 && dac_ramping))
      |-> !resp_q);

  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (resp_valid && !resp_q && $past(cmd_en && cmd_op == 2'b01)) |-> $stable(mode));
endmodule

bind adc_src_sel adc_sel_chk u_chk (
  .clk         (clk),
  .srst_n      (srst_n),
  .mode        (mode_q),
  .arm_q       (arm_q),
  .data_valid  (valid_q),
  .settle_busy (busy),
  .conv_done   (conv_done),
  .dac_change  (dac_change),
  .dac_ramping (dac_ramping),
  .cmd_en      (cmd_en),
  .cmd_op      (cmd_op),
  .resp_valid  (resp_valid),
  .resp_q      (resp_q)
);

// File: tb/sim_adc_src_sel.sv
module sim_adc_src_sel;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 16;
  localparam int CLK_HZ     = 50;
  localparam int SETTLE_MS  = 920;
  localparam int N          = CLK_HZ * SETTLE_MS / 1000;
  localparam int WDOG       = 20000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_en = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [1:0]    cmd_data = 2'b00;
  logic          dac_change = 1'b0;
  logic          dac_ramping = 1'b0;
  logic          conv_done = 1'b0;
  logic [DW-1:0] conv_data = '0;
  logic [1:0]    mode_o;
  logic          data_valid;
  logic          settle_busy;
  logic          resp_valid;
  logic          resp_q;
  logic [DW-1:0] resp_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 1'b0;

  typedef struct {
    logic          q;
    logic [DW-1:0] d;
    string         tag;
  } exp_t;
  exp_t sbq[$];

  adc_src_sel #(.DW(DW), .CLK_HZ(CLK_HZ), .SETTLE_MS(SETTLE_MS)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .dac_change(dac_change), .dac_ramping(dac_ramping),
    .conv_done(conv_done), .conv_data(conv_data), .mode_o(mode_o),
    .data_valid(data_valid), .settle_busy(settle_busy),
    .resp_valid(resp_valid), .resp_q(resp_q), .resp_data(resp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: issue one command, push the expected response.
  task automatic cmd(input logic [1:0] op, input logic [1:0] dat,
                     input logic q, input logic [DW-1:0] d, input string tag);
    exp_t e;
    e.q = q; e.d = d; e.tag = tag;
    sbq.push_back(e);
    @(negedge clk);
    cmd_en = 1'b1; cmd_op = op; cmd_data = dat;
    @(negedge clk);
    cmd_en = 1'b0;
  endtask

  task automatic conv(input logic [DW-1:0] v);
    @(negedge clk);
    conv_done = 1'b1; conv_data = v;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic dac_pulse();
    @(negedge clk);
    dac_change = 1'b1;
    @(negedge clk);
    dac_change = 1'b0;
  endtask

  // Monitor: pop and compare each response.
  always @(negedge clk) begin
    if (resp_valid) begin
      if (sbq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected response actual q=%0b expected none", resp_q);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        check({e.tag, " q"}, 32'(resp_q), 32'(e.q));
        check({e.tag, " data"}, 32'(resp_data), 32'(e.d));
      end
    end
  end

  initial begin
    while (!done && cycles < WDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    // R1 reset state
    check("R1 mode", 32'(mode_o), 0);
    check("R1 valid", 32'(data_valid), 0);
    check("R1 busy", 32'(settle_busy), 1);
    rst_n = 1'b1;
    wait_cyc(N + 4);
    check("R11 settled after reset", 32'(settle_busy), 0);
    conv(16'h1234);
    check("R7 capture sets valid", 32'(data_valid), 1);
    cmd(2'b11, 2'b00, 1'b1, 16'h1234, "R9 read");

    // R2 plain mode switch, R5 invalidation, R11 exact length
    cmd(2'b01, 2'b01, 1'b1, '0, "R2 mode 01");
    check("R2 mode now 01", 32'(mode_o), 1);
    check("R5 valid cleared", 32'(data_valid), 0);
    cmd(2'b11, 2'b00, 1'b0, 16'h1234, "R9 read invalid");
    conv(16'hAAAA);
    check("R7 busy strobe discarded", 32'(data_valid), 0);
    wait_cyc(N - 5);
    check("R11 busy last cycle", 32'(settle_busy), 1);
    wait_cyc(1);
    check("R11 busy ends", 32'(settle_busy), 0);
    cmd(2'b11, 2'b00, 1'b0, 16'h1234, "R7 discarded data kept");
    conv(16'hBBBB);
    cmd(2'b11, 2'b00, 1'b1, 16'hBBBB, "R7 settled capture");

    // R5 same-mode write no effect
    cmd(2'b01, 2'b01, 1'b1, '0, "R5 same mode");
    check("R5 same mode valid", 32'(data_valid), 1);
    check("R5 same mode busy", 32'(settle_busy), 0);

    // R3 / R4 guard
    cmd(2'b01, 2'b11, 1'b0, '0, "R3 unarmed entry");
    check("R3 mode unchanged", 32'(mode_o), 1);
    cmd(2'b00, 2'b00, 1'b1, '0, "R4 arm");
    cmd(2'b10, 2'b00, 1'b1, '0, "R4 other write");
    cmd(2'b01, 2'b11, 1'b0, '0, "R4 arm cleared by write");
    check("R4 mode unchanged", 32'(mode_o), 1);
    cmd(2'b00, 2'b00, 1'b1, '0, "R4 arm again");
    cmd(2'b11, 2'b00, 1'b1, 16'hBBBB, "R4 read keeps arm");
    cmd(2'b01, 2'b11, 1'b1, '0, "R3 armed entry");
    check("R3 mode self-test", 32'(mode_o), 3);

    // R6 DAC change in self-test
    wait_cyc(N + 2);
    conv(16'h0F0F);
    check("R6 valid before dac", 32'(data_valid), 1);
    dac_pulse();
    check("R6 dac self-test valid", 32'(data_valid), 0);
    check("R6 dac self-test busy", 32'(settle_busy), 1);

    // R3 exit guard
    cmd(2'b01, 2'b10, 1'b0, '0, "R3 unarmed exit");
    check("R3 still self-test", 32'(mode_o), 3);
    cmd(2'b00, 2'b00, 1'b1, '0, "R3 arm exit");
    cmd(2'b01, 2'b10, 1'b1, '0, "R3 armed exit");
    check("R3 mode dac monitor", 32'(mode_o), 2);

    // R8 ramping in DAC monitor
    wait_cyc(N + 2);
    conv(16'h5555);
    dac_ramping = 1'b1;
    cmd(2'b11, 2'b00, 1'b0, 16'h5555, "R8 read while ramping");
    conv(16'h6666);
    dac_ramping = 1'b0;
    cmd(2'b11, 2'b00, 1'b1, 16'h5555, "R8 ramp strobe ignored");
    dac_pulse();
    check("R6 dac monitor valid", 32'(data_valid), 0);

    // R6 DAC change off the path
    cmd(2'b01, 2'b01, 1'b1, '0, "R2 mode 01 from 10");
    wait_cyc(N + 2);
    conv(16'h7777);
    dac_pulse();
    check("R6 dac analog valid kept", 32'(data_valid), 1);
    check("R6 dac analog busy", 32'(settle_busy), 0);

    // R10 data survives reset
    wait_cyc(2);
    rst_n = 1'b0;
    wait_cyc(2);
    check("R1 reset mode", 32'(mode_o), 0);
    check("R1 reset valid", 32'(data_valid), 0);
    rst_n = 1'b1;
    wait_cyc(N + 4);
    cmd(2'b11, 2'b00, 1'b0, 16'h7777, "R10 data after reset");
    cmd(2'b01, 2'b11, 1'b0, '0, "R4 reset clears arm");

    wait_cyc(4);
    check("R2 scoreboard drained", 32'(sbq.size()), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule